// File: doc/BRIEF.md
# Serial Memory Status Register and Write-Protection Unit

This block holds the status and control byte of a serial-interface nonvolatile memory and decides whether status writes and array writes may proceed. A command front end, which does the serial shifting, sends it single-cycle event strobes. The strobes cover write enable, write disable, a framed status write carrying its data byte and received bit count, and an array-write request carrying its target address. The array write engine reports its busy level and a completion strobe. The block returns the readable status byte, one-cycle grant or deny pulses for each request, and a registered lock flag for a separate query address.

The register carries a write-enable latch, a busy flag and two range-protect bits. It also carries a status-lock bit that combines with the active-low write-protect pin to form a hardware lock, which can be entered in either order. A granted status write starts a self-timed cycle. The protect and status-lock bits keep their old values until that cycle completes. The protected range is always the top quarter, the top half or the whole of the address space, so the decode follows the address width.

Top module: `sreg_guard`

## Requirements
- R1: After synchronous reset `status` reads 0x00, and `sts_grant`, `sts_deny`, `awr_grant`, `awr_deny`, `chk_locked` and `hw_locked` are 0.
- R2: The status bits are laid out as follows: bit 7 is the status-lock bit, bits 6..4 always read 0, bits 3..2 are the protect field, bit 1 is the write-enable latch and bit 0 is busy. The latch goes to 1 one cycle after `ev_wren` and to 0 one cycle after `ev_wrdi`.
- R3: A status write (`ev_wrsr`) is granted only when all of the following hold: the latch is 1, busy is 0, the hardware lock is inactive and `wrsr_bits` equals 8. Otherwise the block pulses `sts_deny` one cycle later and leaves the status unchanged.
- R4: A granted status write raises busy one cycle after the request and holds it for exactly WR_TICKS cycles. It takes only bits 7, 3 and 2 of `wrsr_data`, and ignores bits 6, 5, 4, 1 and 0.
- R5: While the status-write cycle runs, the status shows the old lock and protect bits with busy at 1 and stays readable, and `chk_locked` follows the old protect field. At completion the new bits appear and the latch clears.
- R6: The hardware lock is active when the status-lock bit is 1 and `wp_n` is 0, whichever became true first. While it is active, status writes are denied. Driving `wp_n` high releases it. `hw_locked` follows one cycle later.
- R7: `chk_locked` is the protect decode of `chk_addr`, registered. In the protect field, 00 protects nothing, 01 protects the top quarter (0x600..0x7FF for 11 address bits), 10 protects the top half (0x400..0x7FF) and 11 protects every address.
- R8: An array-write request (`ev_awr`) is granted only when the latch is 1, busy is 0 and `awr_addr` is outside the protected range. Otherwise the block pulses `awr_deny` one cycle later.
- R9: A high `arr_busy` shows as status bit 0 one cycle later and blocks grants. An `arr_done` strobe clears the write-enable latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_n | input | 1 | Write-protect pin, low asserts protection |
| ev_wren | input | 1 | Write-enable command strobe |
| ev_wrdi | input | 1 | Write-disable command strobe |
| ev_wrsr | input | 1 | Status-write strobe, given at deselect |
| wrsr_bits | input | BITS_W | Data bits received before deselect |
| wrsr_data | input | 8 | New status byte |
| ev_awr | input | 1 | Array-write request strobe |
| awr_addr | input | ADDR_W | Array-write target address |
| arr_busy | input | 1 | Array write engine busy |
| arr_done | input | 1 | Array write completion strobe |
| chk_addr | input | ADDR_W | Address for the protect query |
| status | output | 8 | Readable status byte |
| sts_grant | output | 1 | Status write accepted (pulse) |
| sts_deny | output | 1 | Status write rejected (pulse) |
| awr_grant | output | 1 | Array write accepted (pulse) |
| awr_deny | output | 1 | Array write rejected (pulse) |
| chk_locked | output | 1 | `chk_addr` lies in the protected range |
| hw_locked | output | 1 | Hardware lock active |

## Verification
The bench builds the block with ADDR_W = 11, a 2048-byte space, so the quarter and half boundaries land at 0x600 and 0x400 and can be probed on both sides. WR_TICKS is cut to 12, which makes the length of the busy window countable cycle by cycle. It also leaves room to walk the hardware lock through both entry orders and every protect-field value within a short run. BITS_W = 4 allows frames of 7 and 9 bits next to the correct 8.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  localparam int FRAME_BITS = 8;

  localparam int POS_LOCK = 7;
  localparam int POS_BPH  = 3;
  localparam int POS_BPL  = 2;

  typedef struct packed {
    logic       lock;
    logic [1:0] bp;
  } nvbits_t;

  function automatic nvbits_t take_fields(input logic [7:0] d);
    nvbits_t n;
    n.lock = d[POS_LOCK];
    n.bp   = {d[POS_BPH], d[POS_BPL]};
    return n;
  endfunction

  function automatic logic [7:0] pack_status(input nvbits_t n, input logic wel,
                                             input logic wip);
    return {n.lock, 3'b000, n.bp, wel, wip};
  endfunction

endpackage

// File: rtl/sreg_range_decode.sv
module sreg_range_decode #(
  parameter int ADDR_W = 11
) (
  input  logic [1:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [1:0] top2;
  assign top2 = addr[ADDR_W-1 -: 2];

  always_comb begin
    case (bp)
      2'b00:   hit = 1'b0;
      2'b01:   hit = (top2 == 2'b11);
      2'b10:   hit = top2[1];
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/sreg_cycle_timer.sv
module sreg_cycle_timer #(
  parameter int TICKS = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(TICKS - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  // R4: a new cycle is never launched on top of a running one
  a_r4_start_when_idle: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy_q);
  // R4: the count never exceeds its load value
  a_r4_count_in_range: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q < CW'(TICKS)));
endmodule

// File: rtl/sreg_core.sv
module sreg_core
  import sreg_pkg::*;
#(
  parameter int BITS_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_n,
  input  logic              ev_wren,
  input  logic              ev_wrdi,
  input  logic              ev_wrsr,
  input  logic [BITS_W-1:0] wrsr_bits,
  input  logic [7:0]        wrsr_data,
  input  logic              ev_awr,
  input  logic              awr_locked,
  input  logic              chk_hit,
  input  logic              arr_busy,
  input  logic              arr_done,
  input  logic              tmr_busy,
  input  logic              tmr_done,
  output logic              tmr_start,
  output logic [1:0]        bp_now,
  output logic [7:0]        status,
  output logic              sts_grant,
  output logic              sts_deny,
  output logic              awr_grant,
  output logic              awr_deny,
  output logic              chk_locked,
  output logic              hw_locked
);
  nvbits_t nv_q, pend_q;
  logic wel_q, abusy_q, hpm_q, lock_q;
  logic sgr_q, sdn_q, agr_q, adn_q;
  logic wip, hpm_now, framed, sts_ok, arr_ok;

  assign wip     = tmr_busy | abusy_q;
  assign hpm_now = nv_q.lock & ~wp_n;
  assign framed  = (wrsr_bits == BITS_W'(FRAME_BITS));
  assign sts_ok  = wel_q & ~wip & ~hpm_now & framed;
  assign arr_ok  = wel_q & ~wip & ~awr_locked;

  assign tmr_start = ev_wrsr & sts_ok;
  assign bp_now    = nv_q.bp;

  always_ff @(posedge clk) begin
    if (rst) begin
      nv_q    <= '0;
      pend_q  <= '0;
      wel_q   <= 1'b0;
      abusy_q <= 1'b0;
      hpm_q   <= 1'b0;
      lock_q  <= 1'b0;
      sgr_q   <= 1'b0;
      sdn_q   <= 1'b0;
      agr_q   <= 1'b0;
      adn_q   <= 1'b0;
    end else begin
      sgr_q   <= ev_wrsr & sts_ok;
      sdn_q   <= ev_wrsr & ~sts_ok;
      agr_q   <= ev_awr & arr_ok;
      adn_q   <= ev_awr & ~arr_ok;
      abusy_q <= arr_busy;
      hpm_q   <= hpm_now;
      lock_q  <= chk_hit;
      if (tmr_start) pend_q <= take_fields(wrsr_data);
      if (tmr_done)  nv_q   <= pend_q;
      if (tmr_done | arr_done | ev_wrdi) wel_q <= 1'b0;
      else if (ev_wren)                  wel_q <= 1'b1;
    end
  end

  assign status     = pack_status(nv_q, wel_q, wip);
  assign sts_grant  = sgr_q;
  assign sts_deny   = sdn_q;
  assign awr_grant  = agr_q;
  assign awr_deny   = adn_q;
  assign chk_locked = lock_q;
  assign hw_locked  = hpm_q;

  // R3: status write granted only with latch set and idle
  a_r3_grant_needs_wel: assert property (@(posedge clk) disable iff (rst)
    sgr_q |-> ($past(wel_q) && !$past(wip)));
  // R6: no status write accepted under the hardware lock
  a_r6_no_grant_in_hpm: assert property (@(posedge clk) disable iff (rst)
    sgr_q |-> !$past(hpm_now));
  // R5: protect bits frozen during a running status-write cycle
  a_r5_hold_old_bits: assert property (@(posedge clk) disable iff (rst)
    (tmr_busy && !tmr_done) |=> $stable(nv_q));
  // R8: array write never granted into a protected range
  a_r8_locked_denied: assert property (@(posedge clk) disable iff (rst)
    agr_q |-> !$past(awr_locked));
  // R9: array completion leaves the latch cleared
  a_r9_done_clears_wel: assert property (@(posedge clk) disable iff (rst)
    $past(arr_done) |-> !wel_q);
  // R7: an open protect field locks nothing
  a_r7_open_field: assert property (@(posedge clk) disable iff (rst)
    lock_q |-> ($past(nv_q.bp) != 2'b00));
endmodule

// File: rtl/sreg_guard.sv
module sreg_guard #(
  parameter int ADDR_W   = 11,
  parameter int WR_TICKS = 250000,
  parameter int BITS_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_n,
  input  logic              ev_wren,
  input  logic              ev_wrdi,
  input  logic              ev_wrsr,
  input  logic [BITS_W-1:0] wrsr_bits,
  input  logic [7:0]        wrsr_data,
  input  logic              ev_awr,
  input  logic [ADDR_W-1:0] awr_addr,
  input  logic              arr_busy,
  input  logic              arr_done,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic [7:0]        status,
  output logic              sts_grant,
  output logic              sts_deny,
  output logic              awr_grant,
  output logic              awr_deny,
  output logic              chk_locked,
  output logic              hw_locked
);
  logic       tmr_start, tmr_busy, tmr_done;
  logic [1:0] bp_now;
  logic       awr_hit, chk_hit;

  sreg_cycle_timer #(.TICKS(WR_TICKS)) u_timer (
    .clk(clk), .rst(rst), .start(tmr_start), .busy(tmr_busy), .done(tmr_done)
  );

  sreg_range_decode #(.ADDR_W(ADDR_W)) u_dec_awr (
    .bp(bp_now), .addr(awr_addr), .hit(awr_hit)
  );

  sreg_range_decode #(.ADDR_W(ADDR_W)) u_dec_chk (
    .bp(bp_now), .addr(chk_addr), .hit(chk_hit)
  );

  sreg_core #(.BITS_W(BITS_W)) u_core (
    .clk(clk), .rst(rst), .wp_n(wp_n),
    .ev_wren(ev_wren), .ev_wrdi(ev_wrdi),
    .ev_wrsr(ev_wrsr), .wrsr_bits(wrsr_bits), .wrsr_data(wrsr_data),
    .ev_awr(ev_awr), .awr_locked(awr_hit), .chk_hit(chk_hit),
    .arr_busy(arr_busy), .arr_done(arr_done),
    .tmr_busy(tmr_busy), .tmr_done(tmr_done), .tmr_start(tmr_start),
    .bp_now(bp_now), .status(status),
    .sts_grant(sts_grant), .sts_deny(sts_deny),
    .awr_grant(awr_grant), .awr_deny(awr_deny),
    .chk_locked(chk_locked), .hw_locked(hw_locked)
  );
endmodule

// File: tb/tb_sreg_guard.sv
module tb_sreg_guard;
  localparam int AW = 11;
  localparam int TK = 12;
  localparam int BW = 4;

  localparam int S_STAT = 0, S_SGR = 1, S_SDN = 2, S_AGR = 3, S_ADN = 4,
                 S_LOCK = 5, S_HPM = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wp_n = 1'b1;
  logic ev_wren = 0, ev_wrdi = 0, ev_wrsr = 0, ev_awr = 0;
  logic [BW-1:0] wrsr_bits = '0;
  logic [7:0] wrsr_data = '0;
  logic [AW-1:0] awr_addr = '0, chk_addr = '0;
  logic arr_busy = 0, arr_done = 0;
  logic [7:0] status;
  logic sts_grant, sts_deny, awr_grant, awr_deny, chk_locked, hw_locked;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  string       q_req[$];
  int          q_sig[$];
  logic [31:0] q_exp[$];

  always #5 clk = ~clk;

  sreg_guard #(.ADDR_W(AW), .WR_TICKS(TK), .BITS_W(BW)) dut (
    .clk(clk), .rst(rst), .wp_n(wp_n),
    .ev_wren(ev_wren), .ev_wrdi(ev_wrdi),
    .ev_wrsr(ev_wrsr), .wrsr_bits(wrsr_bits), .wrsr_data(wrsr_data),
    .ev_awr(ev_awr), .awr_addr(awr_addr),
    .arr_busy(arr_busy), .arr_done(arr_done), .chk_addr(chk_addr),
    .status(status), .sts_grant(sts_grant), .sts_deny(sts_deny),
    .awr_grant(awr_grant), .awr_deny(awr_deny),
    .chk_locked(chk_locked), .hw_locked(hw_locked)
  );

  function automatic logic [31:0] pick(input int s);
    case (s)
      S_STAT:  return {24'd0, status};
      S_SGR:   return {31'd0, sts_grant};
      S_SDN:   return {31'd0, sts_deny};
      S_AGR:   return {31'd0, awr_grant};
      S_ADN:   return {31'd0, awr_deny};
      S_LOCK:  return {31'd0, chk_locked};
      default: return {31'd0, hw_locked};
    endcase
  endfunction

  // scoreboard monitor: compares queued expectations one unit after the negedge
  always @(negedge clk) begin
    #1;
    while (q_sig.size() > 0) begin
      string r;
      int s;
      logic [31:0] e, a;
      r = q_req.pop_front();
      s = q_sig.pop_front();
      e = q_exp.pop_front();
      a = pick(s);
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s sig%0d actual=0x%0h expected=0x%0h", r, s, a, e);
      end
    end
  end

  task automatic expect_val(input string r, input int s, input logic [31:0] e);
    q_req.push_back(r);
    q_sig.push_back(s);
    q_exp.push_back(e);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_wren();
    ev_wren = 1; tick(); ev_wren = 0;
  endtask

  task automatic do_wrdi();
    ev_wrdi = 1; tick(); ev_wrdi = 0;
  endtask

  task automatic do_wrsr(input logic [7:0] d, input logic [BW-1:0] n);
    ev_wrsr = 1; wrsr_data = d; wrsr_bits = n; tick(); ev_wrsr = 0;
  endtask

  task automatic do_awr(input logic [AW-1:0] a);
    ev_awr = 1; awr_addr = a; tick(); ev_awr = 0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (status[0] && n < 1000) begin
      n++;
      tick();
    end
    tick();
  endtask

  task automatic probe(input string r, input logic [AW-1:0] a, input logic e);
    chk_addr = a; tick();
    expect_val(r, S_LOCK, {31'd0, e});
  endtask

  task automatic set_status(input logic [7:0] d);
    int n;
    do_wren();
    do_wrsr(d, BW'(8));
    wait_idle(n);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    expect_val("R1", S_STAT, 32'h00);
    expect_val("R1", S_SGR, 0);
    expect_val("R1", S_ADN, 0);
    expect_val("R1", S_LOCK, 0);
    expect_val("R1", S_HPM, 0);
    tick();

    // R2 latch set and clear
    do_wren();
    expect_val("R2", S_STAT, 32'h02);
    do_wrdi();
    expect_val("R2", S_STAT, 32'h00);

    // R3 no latch -> deny
    do_wrsr(8'h8C, BW'(8));
    expect_val("R3", S_SDN, 1);
    expect_val("R3", S_STAT, 32'h00);
    // R3 wrong framing
    do_wren();
    do_wrsr(8'h8C, BW'(7));
    expect_val("R3", S_SDN, 1);
    do_wrsr(8'h8C, BW'(9));
    expect_val("R3", S_SDN, 1);
    expect_val("R3", S_STAT, 32'h02);

    // R4/R5 granted write of 0xFF, only bits 7,3,2 kept
    chk_addr = 11'h7FF;
    do_wrsr(8'hFF, BW'(8));
    expect_val("R4", S_SGR, 1);
    expect_val("R5", S_STAT, 32'h03);
    tick();
    expect_val("R5", S_LOCK, 0);
    expect_val("R5", S_STAT, 32'h03);
    wait_idle(n);
    expect_val("R4 busy length", S_STAT, 32'h8C);
    checks++;
    if (n != TK - 1) begin
      errors++;
      $display("FAIL R4 busy cycles actual=%0d expected=%0d", n + 1, TK);
    end
    expect_val("R5", S_LOCK, 1);

    // R8 whole array locked
    do_wren();
    do_awr(11'h000);
    expect_val("R8", S_ADN, 1);

    // R6 lock bit first, then pin low
    wp_n = 0; tick();
    expect_val("R6", S_HPM, 1);
    do_wrsr(8'h00, BW'(8));
    expect_val("R6", S_SDN, 1);
    expect_val("R6", S_STAT, 32'h8E);
    wp_n = 1; tick();
    expect_val("R6", S_HPM, 0);
    do_wrsr(8'h00, BW'(8));
    expect_val("R6", S_SGR, 1);
    wait_idle(n);
    expect_val("R6", S_STAT, 32'h00);

    // R6 pin low first, then lock bit
    wp_n = 0;
    set_status(8'h80);
    tick();
    expect_val("R6", S_STAT, 32'h80);
    expect_val("R6", S_HPM, 1);
    do_wren();
    do_wrsr(8'h00, BW'(8));
    expect_val("R6", S_SDN, 1);
    wp_n = 1; tick();
    do_wrsr(8'h04, BW'(8));
    expect_val("R6", S_SGR, 1);
    wait_idle(n);
    tick();
    expect_val("R6", S_STAT, 32'h04);

    // R7 decode boundaries
    probe("R7", 11'h5FF, 0);
    probe("R7", 11'h600, 1);
    probe("R7", 11'h7FF, 1);
    set_status(8'h08);
    probe("R7", 11'h3FF, 0);
    probe("R7", 11'h400, 1);
    // R8 half locked
    do_wren();
    do_awr(11'h3FF);
    expect_val("R8", S_AGR, 1);
    do_awr(11'h400);
    expect_val("R8", S_ADN, 1);
    set_status(8'h0C);
    probe("R7", 11'h000, 1);
    set_status(8'h00);
    probe("R7", 11'h7FF, 0);

    // R8/R9 array write flow
    do_wren();
    do_awr(11'h123);
    expect_val("R8", S_AGR, 1);
    arr_busy = 1; tick();
    expect_val("R9", S_STAT, 32'h03);
    do_awr(11'h124);
    expect_val("R9", S_ADN, 1);
    do_wrsr(8'h04, BW'(8));
    expect_val("R3", S_SDN, 1);
    arr_busy = 0; arr_done = 1; tick(); arr_done = 0;
    tick();
    expect_val("R9", S_STAT, 32'h00);
    do_awr(11'h010);
    expect_val("R8", S_ADN, 1);

    repeat (3) tick();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule